// File: doc/BRIEF.md
# Low-Power Standby Mode Controller

This block sequences a small microcontroller into and out of its standby levels. Software writes a four-bit control word that can ask for a light sleep, a time-base-timer hold or a full stop. The word also carries a pin-state choice. A clock-source input tells the block whether the core runs from the PLL or from the main oscillator, and that input picks which sleep variant applies. From the current level the block drives enables for the oscillator, the CPU clock, the peripheral clock and the time-base/watch timers. It also drives the pin controls: hold the outputs, or force them to high impedance with peripheral outputs disabled.

Any enabled interrupt request ends a standby level, and so does a reset. Leaving stop goes through an oscillator warm-up window whose length is set by an input count, and the CPU clock comes back only after that window. Leaving a sleep or timer level restores the CPU clock on the very next cycle. When standby ends, the request bits in the control word clear by themselves.

Top module: `standby_ctrl`

## Requirements
- R1: After reset the level code is 0 (run). Oscillator, CPU clock, peripheral clock and timer enables are all 1, and pinHold, pinHiZ and periOutDis are 0. The readback is 4'b0100.
- R2: The control word has these fields: bit0 asks for sleep, bit1 asks for stop, bit 2 asks for timer mode when 0, and bit3 selects the pin state. A write in run with no interrupt pending takes effect at the next clock edge. During standby the readback returns the written word. The level codes are: 0 run, 1 PLL sleep, 2 main sleep, 3 timer mode, 4 stop, 5 warm-up.
- R3: A sleep request gives code 1 when clkSelMain is 0 and code 2 when it is 1. In both sleep levels the CPU clock is off, the oscillator, peripheral clock and timers stay on, pinHold is 1 and pinHiZ is 0.
- R4: In timer mode the oscillator and timers are on, and the CPU and peripheral clocks are off.
- R5: In stop the oscillator, CPU clock, peripheral clock and timers are all off.
- R6: In timer mode, stop and warm-up, a pin-select of 0 gives pinHold=1 and pinHiZ=0. A pin-select of 1 gives pinHold=0, pinHiZ=1 and periOutDis=1. In run, all three pin controls are 0.
- R7: When several requests are written together, stop wins over timer mode, and timer mode wins over sleep.
- R8: An interrupt in either sleep level or in timer mode returns the block to run at the next edge.
- R9: An interrupt in stop moves the block to warm-up, which lasts wakeWait+1 cycles with the oscillator on and the CPU clock off. The block then returns to run.
- R10: On release the readback becomes {pin-select, 1, 0, 0}, so the pin-select bit is kept and the request bits are cleared.
- R11: A write made while an interrupt is pending leaves the block in run. Only the pin-select bit is stored, and the readback becomes {bit3, 1, 0, 0}.
- R12: An asynchronous reset taken during standby returns the block to the run state at once.
- R13: Writes made outside run change neither the level nor the readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Control word write strobe |
| regWdata | input | 4 | Control word write data |
| clkSelMain | input | 1 | 0 = PLL clock, 1 = main oscillator clock |
| irqPending | input | 1 | Any enabled interrupt request |
| wakeWait | input | CNT_W | Warm-up length after stop, minus one |
| regRdata | output | 4 | Control word readback |
| stbyMode | output | 3 | Current level code |
| oscEn | output | 1 | Main oscillator enable |
| cpuClkEn | output | 1 | CPU clock enable |
| periClkEn | output | 1 | Peripheral clock enable |
| timerEn | output | 1 | Time-base and watch timer enable |
| pinHold | output | 1 | Hold pin states |
| pinHiZ | output | 1 | Force pins to high impedance |
| periOutDis | output | 1 | Disable peripheral outputs on shared pins |

## Verification
The bench writes every control-word value under both clock sources, with and without a pending interrupt. This exposes a wrong priority order and a swapped sleep variant, and it catches a pending interrupt that fails to block entry. The last of these would leave the core halted. The stop path is exercised with several warm-up counts, so a window that is one cycle short or one cycle long shows up as an early or late return to run. Writes during standby, reset taken in stop, and the readback after wake-up are also checked. Respectively, these catch a design that leaves standby on a stray write, one that keeps its clocks gated after reset, and one that leaves stale request bits behind.

// File: rtl/stby_pkg.sv
`timescale 1ns/1ps
package stby_pkg;

  localparam int CTRL_W   = 4;
  localparam int BIT_SLP  = 0;
  localparam int BIT_STP  = 1;
  localparam int BIT_TBTN = 2;
  localparam int BIT_PIN  = 3;

  typedef enum logic [2:0] {
    MODE_RUN    = 3'd0,
    MODE_PSLEEP = 3'd1,
    MODE_MSLEEP = 3'd2,
    MODE_TBT    = 3'd3,
    MODE_STOP   = 3'd4,
    MODE_WARM   = 3'd5
  } stbyMode_e;

  typedef struct packed {
    logic wrPin;
    logic latchReq;
    logic clrReq;
    logic loadCnt;
    logic decCnt;
  } dpStrobe_t;

endpackage

// File: rtl/stby_datapath.sv
`timescale 1ns/1ps
module stby_datapath
  import stby_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [CTRL_W-1:0] wrData,
  input  logic [CNT_W-1:0]  wakeWait,
  output logic [CTRL_W-1:0] rdData,
  output logic              pinSel,
  output logic              cntZero
);

  logic             sleepBit;
  logic             stopBit;
  logic             tbtBit;
  logic             pinBit;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleepBit <= 1'b0;
      stopBit  <= 1'b0;
      tbtBit   <= 1'b1;
    end else if (strobe.clrReq) begin
      sleepBit <= 1'b0;
      stopBit  <= 1'b0;
      tbtBit   <= 1'b1;
    end else if (strobe.latchReq) begin
      sleepBit <= wrData[BIT_SLP];
      stopBit  <= wrData[BIT_STP];
      tbtBit   <= wrData[BIT_TBTN];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pinBit <= 1'b0;
    else if (strobe.wrPin)  pinBit <= wrData[BIT_PIN];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (strobe.loadCnt) cnt <= wakeWait;
    else if (strobe.decCnt)  cnt <= cnt - 1'b1;
  end

  always_comb begin
    rdData            = '0;
    rdData[BIT_SLP]   = sleepBit;
    rdData[BIT_STP]   = stopBit;
    rdData[BIT_TBTN]  = tbtBit;
    rdData[BIT_PIN]   = pinBit;
  end

  assign pinSel  = pinBit;
  assign cntZero = (cnt == '0);

  // R9: warm-up count steps down by one per cycle
  a_r9_count_down: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decCnt |=> cnt == ($past(cnt) - 1'b1));

  // R10: release leaves the request bits in their idle values
  a_r10_release_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrReq |=> (tbtBit && !stopBit && !sleepBit));

endmodule

// File: rtl/stby_control.sv
`timescale 1ns/1ps
module stby_control
  import stby_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [2:0] reqBits,
  input  logic       clkSelMain,
  input  logic       irqPending,
  input  logic       cntZero,
  input  logic       pinSel,
  output stbyMode_e  curMode,
  output dpStrobe_t  strobe,
  output logic       oscEn,
  output logic       cpuClkEn,
  output logic       periClkEn,
  output logic       timerEn,
  output logic       pinHold,
  output logic       pinHiZ,
  output logic       periOutDis
);

  stbyMode_e nxtMode;
  logic      sleepLvl;
  logic      deepLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curMode <= MODE_RUN;
    else       curMode <= nxtMode;
  end

  always_comb begin
    nxtMode = curMode;
    strobe  = '0;
    case (curMode)
      MODE_RUN: begin
        if (regWe) begin
          strobe.wrPin = 1'b1;
          if (!irqPending) begin
            if (reqBits[BIT_STP])        nxtMode = MODE_STOP;
            else if (!reqBits[BIT_TBTN]) nxtMode = MODE_TBT;
            else if (reqBits[BIT_SLP])   nxtMode = clkSelMain ? MODE_MSLEEP : MODE_PSLEEP;
            strobe.latchReq = (nxtMode != MODE_RUN);
          end
        end
      end
      MODE_PSLEEP, MODE_MSLEEP, MODE_TBT: begin
        if (irqPending) begin
          nxtMode       = MODE_RUN;
          strobe.clrReq = 1'b1;
        end
      end
      MODE_STOP: begin
        if (irqPending) begin
          nxtMode        = MODE_WARM;
          strobe.clrReq  = 1'b1;
          strobe.loadCnt = 1'b1;
        end
      end
      MODE_WARM: begin
        if (cntZero) nxtMode = MODE_RUN;
        else         strobe.decCnt = 1'b1;
      end
      default: nxtMode = MODE_RUN;
    endcase
  end

  assign sleepLvl   = (curMode == MODE_PSLEEP) || (curMode == MODE_MSLEEP);
  assign deepLvl    = (curMode == MODE_TBT) || (curMode == MODE_STOP) || (curMode == MODE_WARM);
  assign oscEn      = (curMode != MODE_STOP);
  assign cpuClkEn   = (curMode == MODE_RUN);
  assign periClkEn  = (curMode == MODE_RUN) || sleepLvl;
  assign timerEn    = (curMode == MODE_RUN) || sleepLvl || (curMode == MODE_TBT);
  assign pinHiZ     = deepLvl && pinSel;
  assign pinHold    = sleepLvl || (deepLvl && !pinSel);
  assign periOutDis = pinHiZ;

  // R6: hold and high impedance are never requested together
  a_r6_pin_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(pinHold && pinHiZ));

  // R7: a stop request wins over every other request
  a_r7_stop_wins: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_RUN && regWe && !irqPending && reqBits[BIT_STP]) |=> curMode == MODE_STOP);

  // R8: interrupt in a sleep level or timer mode returns to run
  a_r8_wake_to_run: assert property (@(posedge clk) disable iff (!rstN)
    ((sleepLvl || curMode == MODE_TBT) && irqPending) |=> (curMode == MODE_RUN && cpuClkEn));

  // R9: interrupt in stop goes through warm-up
  a_r9_stop_to_warm: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_STOP && irqPending) |=> (curMode == MODE_WARM && oscEn && !cpuClkEn));

  // R11: pending interrupt cancels any entry
  a_r11_cancel: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_RUN && irqPending) |=> curMode == MODE_RUN);

  // R13: a standby level is not left on a write
  a_r13_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (curMode != MODE_RUN && curMode != MODE_WARM && !irqPending) |=> $stable(curMode));

endmodule

// File: rtl/standby_ctrl.sv
`timescale 1ns/1ps
module standby_ctrl
  import stby_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [3:0]       regWdata,
  input  logic             clkSelMain,
  input  logic             irqPending,
  input  logic [CNT_W-1:0] wakeWait,
  output logic [3:0]       regRdata,
  output logic [2:0]       stbyMode,
  output logic             oscEn,
  output logic             cpuClkEn,
  output logic             periClkEn,
  output logic             timerEn,
  output logic             pinHold,
  output logic             pinHiZ,
  output logic             periOutDis
);

  dpStrobe_t strobe;
  stbyMode_e curMode;
  logic      cntZero;
  logic      pinSel;

  stby_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWe      (regWe),
    .reqBits    (regWdata[2:0]),
    .clkSelMain (clkSelMain),
    .irqPending (irqPending),
    .cntZero    (cntZero),
    .pinSel     (pinSel),
    .curMode    (curMode),
    .strobe     (strobe),
    .oscEn      (oscEn),
    .cpuClkEn   (cpuClkEn),
    .periClkEn  (periClkEn),
    .timerEn    (timerEn),
    .pinHold    (pinHold),
    .pinHiZ     (pinHiZ),
    .periOutDis (periOutDis)
  );

  stby_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (regWdata),
    .wakeWait (wakeWait),
    .rdData   (regRdata),
    .pinSel   (pinSel),
    .cntZero  (cntZero)
  );

  assign stbyMode = curMode;

endmodule

// File: tb/sim_standby_ctrl.sv
`timescale 1ns/1ps
module sim_standby_ctrl;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             regWe = 1'b0;
  logic [3:0]       regWdata = '0;
  logic             clkSelMain = 1'b0;
  logic             irqPending = 1'b0;
  logic [CNT_W-1:0] wakeWait = '0;
  logic [3:0]       regRdata;
  logic [2:0]       stbyMode;
  logic             oscEn, cpuClkEn, periClkEn, timerEn, pinHold, pinHiZ, periOutDis;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  standby_ctrl #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .clkSelMain(clkSelMain), .irqPending(irqPending), .wakeWait(wakeWait),
    .regRdata(regRdata), .stbyMode(stbyMode), .oscEn(oscEn), .cpuClkEn(cpuClkEn),
    .periClkEn(periClkEn), .timerEn(timerEn), .pinHold(pinHold), .pinHiZ(pinHiZ),
    .periOutDis(periOutDis)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // level code from written word: stop > timer (bit2 low) > sleep
  function automatic int expMode(input logic [3:0] wd, input logic sel, input logic irq);
    if (irq)        return 0;
    if (wd[1])      return 4;
    if (!wd[2])     return 3;
    if (wd[0])      return sel ? 2 : 1;
    return 0;
  endfunction

  // {osc, cpu, peri, timer, hold, hiz, dis}
  function automatic logic [6:0] expOut(input int m, input logic pin);
    logic deep;
    deep = (m == 3 || m == 4 || m == 5);
    case (m)
      0:       return 7'b1111000;
      1, 2:    return 7'b1011100;
      3:       return {4'b1001, ~pin, pin, pin};
      4:       return {4'b0000, ~pin, pin, pin};
      5:       return {4'b1000, ~pin, pin, pin};
      default: return {4'b0000, deep, 2'b00};
    endcase
  endfunction

  function automatic string modeReq(input int m);
    case (m)
      1, 2:    return "R3";
      3:       return "R4";
      4:       return "R5";
      default: return "R1";
    endcase
  endfunction

  function automatic logic [6:0] outs();
    return {oscEn, cpuClkEn, periClkEn, timerEn, pinHold, pinHiZ, periOutDis};
  endfunction

  initial begin
    #400000;
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int em;
    logic [3:0] expRd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 mode", int'(stbyMode), 0);
    chk("R1 enables", int'(outs()), int'(7'b1111000));
    chk("R1 readback", int'(regRdata), 4'b0100);

    for (int sel = 0; sel < 2; sel++) begin
      for (int irq = 0; irq < 2; irq++) begin
        for (int wd = 0; wd < 16; wd++) begin
          wakeWait   = CNT_W'(wd % 4);
          clkSelMain = sel[0];
          irqPending = irq[0];
          regWe      = 1'b1;
          regWdata   = wd[3:0];
          @(negedge clk);
          regWe      = 1'b0;
          irqPending = 1'b0;
          em = expMode(wd[3:0], sel[0], irq[0]);
          expRd = (em != 0) ? wd[3:0] : {wd[3], 3'b100};
          chk(irq != 0 ? "R11 mode" : "R7 R2 mode", int'(stbyMode), em);
          chk(irq != 0 ? "R11 readback" : "R2 readback", int'(regRdata), int'(expRd));
          chk({modeReq(em), " R6 outputs"}, int'(outs()), int'(expOut(em, wd[3])));
          if (em != 0) begin
            // R13: write during standby must not change anything
            regWe    = 1'b1;
            regWdata = ~wd[3:0];
            @(negedge clk);
            regWe = 1'b0;
            chk("R13 mode", int'(stbyMode), em);
            chk("R13 readback", int'(regRdata), int'(expRd));
            irqPending = 1'b1;
            @(negedge clk);
            irqPending = 1'b0;
            if (em == 4) begin
              chk("R9 warm mode", int'(stbyMode), 5);
              chk("R9 warm outputs", int'(outs()), int'(expOut(5, wd[3])));
              for (int k = 1; k <= wd % 4; k++) begin
                @(negedge clk);
                chk("R9 warm hold", int'(stbyMode), 5);
              end
              @(negedge clk);
            end
            chk(em == 4 ? "R9 run" : "R8 run", int'(stbyMode), 0);
            chk("R8 cpu clock", int'(cpuClkEn), 1);
            chk("R10 readback", int'(regRdata), int'({wd[3], 3'b100}));
          end
        end
      end
    end

    // R12: asynchronous reset from stop
    regWe = 1'b1; regWdata = 4'b1010;
    @(negedge clk);
    regWe = 1'b0;
    chk("R12 entered stop", int'(stbyMode), 4);
    #1 rstN = 1'b0;
    #0.5;
    chk("R12 mode", int'(stbyMode), 0);
    chk("R12 enables", int'(outs()), int'(7'b1111000));
    chk("R12 readback", int'(regRdata), 4'b0100);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule